// File: doc/BRIEF.md
# Segment Display Data RAM Write Port

This block keeps the picture for a multiplexed segment display that drives four common lines. Its storage has one 4-bit entry per segment, 36 entries by default, and each bit of an entry belongs to one common line. A command decoder sends an address-load strobe with a segment address. A serial receiver sends a stream of nibble strobes. The block writes each nibble at the current write pointer and then steps the pointer by one. After the last segment the pointer wraps back to segment zero, so a run of bytes can keep arriving without limit. Each byte the receiver collects produces two nibbles, and those two nibbles fill two neighbouring segments.

The receiver passes each nibble with the earliest received bit in the most significant position of `nib_data`. Inside the block the bit order is reversed on the way to the common lines, so the earliest received bit drives common line 0. Display scan logic reads entries back through a separate registered read port that is addressed by segment.

Top module: `seg_ram_writer`

## Requirements
- R1: After reset every entry is 0, the write pointer is 0 and `rd_data` is 0.
- R2: When `addr_load` is high with `addr_value` in the range 0..35, the pointer takes that value, and the next nibble is written to that segment.
- R3: Each `nib_valid` cycle writes one entry at the pointer, and the pointer then advances by one.
- R4: A nibble written at segment 35 (0x23) moves the pointer to 0.
- R5: When `addr_value` is above 35 on an address load, the pointer is set to 0.
- R6: When `addr_load` and `nib_valid` are high in the same cycle, the nibble goes to the newly loaded address, and the pointer moves to the entry after it.
- R7: Bit mapping: `nib_data[3]` (the first serial bit) is stored as entry bit 0 (COM0), and `nib_data[0]` (the fourth serial bit) is stored as entry bit 3 (COM3).
- R8: A received byte arrives as two consecutive nibbles and fills two consecutive segments. Streams of any length keep writing, including across the wrap.
- R9: `rd_data` holds the entry at `rd_addr` one clock after the address is presented. A `rd_addr` above 35 returns 0.
- R10: An address load without a nibble changes no entry.
- R11: A read in the same cycle as a write to the same segment returns the content from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_load | input | 1 | Load strobe for the write pointer |
| addr_value | input | 6 | Segment address to load |
| nib_valid | input | 1 | Nibble write strobe |
| nib_data | input | 4 | Nibble, earliest serial bit in bit 3 |
| rd_addr | input | 6 | Segment address to read |
| rd_data | output | 4 | Entry read out, one cycle later |

## Verification
A write shows up in the stored entry at the clock edge that samples the strobe. The only way to see it is the read port, which adds one more edge. The bench therefore drives each stimulus one nanosecond after a rising edge, waits one edge, and compares `rd_data` against the model entry for `rd_addr` as the model stood before that edge's write. That comparison also covers R11. The model then applies the write and pointer update, so every pointer step, wrap and clamp is confirmed by later reads.

// File: rtl/seg_ram_pkg.sv
package seg_ram_pkg;
   localparam int DEF_SEG_COUNT = 36;
   localparam int DEF_COM_COUNT = 4;

   typedef enum logic {
      ORDER_DIRECT   = 1'b0,
      ORDER_REVERSED = 1'b1
   } bit_order_e;
endpackage

// File: rtl/seg_ptr.sv
module seg_ptr #(
   parameter int SEG_COUNT = 36,
   parameter int ADDR_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_value,
   input  logic              advance,
   output logic [ADDR_W-1:0] wr_addr
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SEG_COUNT - 1);

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] clamped;
   logic [ADDR_W-1:0] ptr_next;

   // out-of-range loads fall back to the first segment
   always_comb begin
      clamped = (load_value > LAST) ? '0 : load_value;
      wr_addr = load ? clamped : ptr_q;
   end

   always_comb begin
      ptr_next = wr_addr;
      if (advance) begin
         ptr_next = (wr_addr == LAST) ? '0 : wr_addr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_next;
   end

   assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST);

   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && ptr_q == LAST) |=> ptr_q == '0);

   assert_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !advance && load_value > LAST) |=> ptr_q == '0);

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !advance && load_value <= LAST) |=> ptr_q == $past(load_value));

   assert_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && advance && load_value < LAST) |=> ptr_q == $past(load_value) + 1'b1);
endmodule

// File: rtl/nib_reorder.sv
module nib_reorder
   import seg_ram_pkg::*;
#(
   parameter int         COM_COUNT = 4,
   parameter bit_order_e ORDER     = ORDER_REVERSED
) (
   input  logic [COM_COUNT-1:0] serial_nib,
   output logic [COM_COUNT-1:0] com_bits
);
   generate
      if (ORDER == ORDER_REVERSED) begin : g_rev
         for (genvar b = 0; b < COM_COUNT; b++) begin : g_bit
            assign com_bits[b] = serial_nib[COM_COUNT-1-b];
         end
      end else begin : g_dir
         assign com_bits = serial_nib;
      end
   endgenerate

   always_comb begin
      assert_popcount_R7: assert ($countones(com_bits) == $countones(serial_nib));
   end
endmodule

// File: rtl/seg_store.sv
module seg_store #(
   parameter int SEG_COUNT = 36,
   parameter int COM_COUNT = 4,
   parameter int ADDR_W    = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    waddr,
   input  logic [COM_COUNT-1:0] wdata,
   input  logic [ADDR_W-1:0]    raddr,
   output logic [COM_COUNT-1:0] rdata
);
   logic [SEG_COUNT-1:0][COM_COUNT-1:0] mem;
   logic [COM_COUNT-1:0]                rsel;

   generate
      for (genvar i = 0; i < SEG_COUNT; i++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            mem[i] <= '0;
            else if (we && waddr == ADDR_W'(i))    mem[i] <= wdata;
         end
      end
   endgenerate

   // unmatched addresses read as zero
   always_comb begin
      rsel = '0;
      for (int k = 0; k < SEG_COUNT; k++) begin
         if (raddr == ADDR_W'(k)) rsel = mem[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rsel;
   end

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mem));

   assert_single_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> $countones(mem ^ $past(mem)) <= COM_COUNT);
endmodule

// File: rtl/seg_ram_writer.sv
module seg_ram_writer
   import seg_ram_pkg::*;
#(
   parameter int         SEG_COUNT = DEF_SEG_COUNT,
   parameter int         COM_COUNT = DEF_COM_COUNT,
   parameter bit_order_e BIT_ORDER = ORDER_REVERSED,
   localparam int        ADDR_W    = $clog2(SEG_COUNT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 addr_load,
   input  logic [ADDR_W-1:0]    addr_value,
   input  logic                 nib_valid,
   input  logic [COM_COUNT-1:0] nib_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [COM_COUNT-1:0] rd_data
);
   generate
      if (SEG_COUNT < 2) begin : g_bad_seg
         $error("SEG_COUNT must be at least 2");
      end
      if (COM_COUNT < 1) begin : g_bad_com
         $error("COM_COUNT must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0]    wr_addr;
   logic [COM_COUNT-1:0] com_bits;

   seg_ptr #(.SEG_COUNT(SEG_COUNT), .ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(addr_load), .load_value(addr_value),
      .advance(nib_valid), .wr_addr(wr_addr));

   nib_reorder #(.COM_COUNT(COM_COUNT), .ORDER(BIT_ORDER)) u_reorder (
      .serial_nib(nib_data), .com_bits(com_bits));

   seg_store #(.SEG_COUNT(SEG_COUNT), .COM_COUNT(COM_COUNT), .ADDR_W(ADDR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(nib_valid), .waddr(wr_addr),
      .wdata(com_bits), .raddr(rd_addr), .rdata(rd_data));

   assert_rd_oob_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr > ADDR_W'(SEG_COUNT - 1)) |=> rd_data == '0);

   assert_wr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      nib_valid |-> wr_addr < ADDR_W'(SEG_COUNT));
endmodule

// File: tb/seg_ram_writer_test.sv
`timescale 1ns/1ps
module seg_ram_writer_test;
   localparam int NSEG = 36;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_load = 1'b0;
   logic [5:0] addr_value = '0;
   logic       nib_valid = 1'b0;
   logic [3:0] nib_data = '0;
   logic [5:0] rd_addr = '0;
   logic [3:0] rd_data;

   int checks = 0;
   int errors = 0;
   logic [3:0] model [NSEG];
   int ptr = 0;

   always #5 clk = ~clk;

   seg_ram_writer uut (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_value(addr_value),
      .nib_valid(nib_valid), .nib_data(nib_data), .rd_addr(rd_addr), .rd_data(rd_data));

   function automatic int clamp(input logic [5:0] a);
      return (a > 6'd35) ? 0 : int'(a);
   endfunction

   function automatic logic [3:0] reorder(input logic [3:0] n);
      logic [3:0] r;
      for (int b = 0; b < 4; b++) r[b] = n[3-b];
      return r;
   endfunction

   task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: rd_data=%h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic ld, input logic [5:0] av, input logic nv,
                       input logic [3:0] nd, input logic [5:0] ra, input string tag);
      logic [3:0] exp;
      int a;
      addr_load = ld; addr_value = av; nib_valid = nv; nib_data = nd; rd_addr = ra;
      exp = (ra < NSEG) ? model[ra] : 4'h0;   // R11: old content
      @(posedge clk); #1;
      a = ld ? clamp(av) : ptr;
      if (nv) begin
         model[a] = reorder(nd);
         ptr = (a == NSEG - 1) ? 0 : a + 1;
      end else begin
         ptr = a;
      end
      check(rd_data, exp, tag);
   endtask

   task automatic scan(input string tag);
      for (int s = 0; s < NSEG; s++) step(1'b0, 6'd0, 1'b0, 4'h0, 6'(s), tag);
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int s = 0; s < NSEG; s++) model[s] = 4'h0;
      #12;
      check(rd_data, 4'h0, "R1 reset output");
      #20 rst_n = 1'b1;
      @(posedge clk); #1;
      scan("R1 reset contents");
      // R2 R3 R7 R8: byte 0xA3 at segment 5 -> seg5 = rev(A)=5, seg6 = rev(3)=C
      step(1'b1, 6'd5, 1'b0, 4'h0, 6'd0, "R2 load");
      step(1'b0, 6'd0, 1'b1, 4'hA, 6'd0, "R3 first nibble");
      step(1'b0, 6'd0, 1'b1, 4'h3, 6'd5, "R8 second nibble");
      step(1'b0, 6'd0, 1'b0, 4'h0, 6'd5, "R7 seg5");
      check(rd_data, 4'h5, "R7 COM order seg5");
      step(1'b0, 6'd0, 1'b0, 4'h0, 6'd6, "R8 seg6");
      check(rd_data, 4'hC, "R7 COM order seg6");
      // R4 wrap at 35
      step(1'b1, 6'd35, 1'b0, 4'h0, 6'd0, "R4 load");
      step(1'b0, 6'd0, 1'b1, 4'h8, 6'd0, "R4 write 35");
      step(1'b0, 6'd0, 1'b1, 4'h1, 6'd35, "R4 write wrapped");
      check(rd_data, 4'h1, "R4 seg35 value");
      step(1'b0, 6'd0, 1'b0, 4'h0, 6'd0, "R4 seg0");
      check(rd_data, 4'h8, "R4 wrapped seg0 value");
      // R5 clamp
      step(1'b1, 6'd50, 1'b0, 4'h0, 6'd0, "R5 load oob");
      step(1'b0, 6'd0, 1'b1, 4'hF, 6'd0, "R5 write");
      step(1'b0, 6'd0, 1'b0, 4'h0, 6'd0, "R5 seg0");
      check(rd_data, 4'hF, "R5 clamped to seg0");
      // R6 collide
      step(1'b1, 6'd10, 1'b1, 4'h2, 6'd10, "R6 collide");
      step(1'b0, 6'd0, 1'b1, 4'h6, 6'd10, "R6 next");
      step(1'b0, 6'd0, 1'b0, 4'h0, 6'd11, "R6 seg11");
      check(rd_data, 4'h6, "R6 seg11 value");
      // R11 same-cycle read/write
      step(1'b1, 6'd20, 1'b1, 4'h1, 6'd20, "R11 read during write");
      step(1'b0, 6'd0, 1'b0, 4'h0, 6'd20, "R11 after write");
      check(rd_data, 4'h8, "R11 new content");
      // R10 load only
      step(1'b1, 6'd3, 1'b0, 4'hF, 6'd3, "R10 load only");
      step(1'b1, 6'd40, 1'b0, 4'hF, 6'd0, "R10 oob load only");
      scan("R10 no entry changed");
      // R9 out-of-range read
      step(1'b0, 6'd0, 1'b0, 4'h0, 6'd36, "R9 oob read");
      step(1'b0, 6'd0, 1'b0, 4'h0, 6'd63, "R9 oob read max");
      // random mix
      void'($urandom(32'd1234));
      for (int n = 0; n < 4000; n++) begin
         logic ld;
         ld = ($urandom % 10) == 0;
         step(ld, 6'($urandom % 48), ($urandom % 4) != 0, 4'($urandom),
              6'($urandom % 40), "R8 random stream");
      end
      scan("R8 final contents");
      finish_run();
   end
endmodule